// File: doc/BRIEF.md
# Serial Port Configuration Gate

This block is the register front end of an asynchronous serial port. It holds the frame, clock, pin and baud settings that the serial core needs. It also controls when that core may run. Two switches decide this. A module enable bit must be set before any other register accepts a write. An active-low software reset bit keeps the core idle while software programs the other settings, in any order.

Settings that the core uses are presented on dedicated outputs. Those outputs follow the registers only while the core runs. While the core is held in reset they keep the last value the core ran with. The block also contains the line multiplexing between the core and the pins. It provides an internal loopback path from the core's transmit line to its receive input for self-test. It also selects whether the pins carry serial traffic at all. Software reaches the registers through a small synchronous bus: writes commit on the clock edge, and reads return data combinationally.

Top module: `uart_cfg_gate`

## Requirements
- R1: After a hard reset (rstN low), coreInReset is 1, txRun and rxRun are 0, loopOn is 0, baudDiv is 1, txPin and coreRx are 1, and every register reads 0.
- R2: While the module enable is 0, bus writes to addresses 1, 2 and 3 are dropped without any response, and those addresses read 0.
- R3: Address 0 bit 0 is the module enable and can always be written. Writing it to 0 returns addresses 1 to 3 to their reset values, visible from the cycle after the write.
- R4: coreInReset is 1 unless the module enable is 1 and the software reset bit (address 1 bit 0, active low, resets to 0) is 1.
- R5: The core-facing settings (baudDiv; loopOn from address 1 bit 3; clkIntSel from bit 4; finishOnHalt from bit 5; parityEn from bit 6; twoStop from bit 7) follow the registers while the core runs. While coreInReset is 1 they hold the values from the last cycle the core ran, or their defaults if it has not run. New values appear in the first cycle the core runs.
- R6: txRun is 1 only when the core runs and address 1 bit 1 is 1. rxRun is 1 only when the core runs and address 1 bit 2 is 1. Clearing the software reset bit drops both in the next cycle, and the register contents are kept.
- R7: While loopOn is 1, coreRx equals coreTx, txPin is 1, and rxPin has no effect.
- R8: pinSerial is 1 only when both address 2 bit 0 (receive pin function) and bit 1 (transmit pin function) are 1. Without loopback, txPin follows coreTx and coreRx follows rxPin when pinSerial is 1. Otherwise both txPin and coreRx are 1.
- R9: Address 3 holds a 24-bit baud divisor taken from write data bits 23:0, and the upper write bits are ignored. A stored divisor of 0 appears on baudDiv as 1.
- R10: busRdata shows the register selected by busAddr in the same cycle that busSel is 1 without a write. It is 0 when busSel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write when 1, read when 0 |
| busAddr | input | 2 | Register address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| coreTx | input | 1 | Transmit line from the serial core |
| rxPin | input | 1 | External receive pin |
| coreInReset | output | 1 | Serial core held in reset |
| txRun | output | 1 | Transmitter allowed to run |
| rxRun | output | 1 | Receiver allowed to run |
| loopOn | output | 1 | Internal loopback active |
| clkIntSel | output | 1 | Internal clock selected |
| finishOnHalt | output | 1 | Let a transfer in progress finish before a debug halt |
| parityEn | output | 1 | Parity enabled |
| twoStop | output | 1 | Two stop bits |
| baudDiv | output | 24 | Baud divisor applied to the core, never 0 |
| pinSerial | output | 1 | Pins driven by the serial function |
| txPin | output | 1 | External transmit pin |
| coreRx | output | 1 | Receive line to the serial core |

## Verification
A write commits on the rising edge at the end of its bus cycle. Every state-dependent result (coreInReset, txRun, rxRun, baudDiv and the other core settings, read data, and pin routing) is therefore due one clock edge after the write, with no further pipeline. The bench drives the bus on the falling edge and checks on the next falling edge, after that single commit edge. Read data and the pin multiplexer are combinational, so the bench samples them a short delay after changing busAddr, coreTx or rxPin, within the same cycle and with no clock edge between.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 32;
  localparam int BAUD_W  = 24;
  localparam int CTRL_W  = 8;
  localparam int PINS_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PINS   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_BAUD   = 2'd3;

  // control register, bit 0 at the bottom
  typedef struct packed {
    logic twoStop;
    logic parityEn;
    logic finishOnHalt;
    logic intClk;
    logic loopSel;
    logic rxEn;
    logic txEn;
    logic softRstN;
  } ctrlReg_t;

  // settings presented to the serial core
  typedef struct packed {
    logic [BAUD_W-1:0] baud;
    logic              twoStop;
    logic              parityEn;
    logic              finishOnHalt;
    logic              intClk;
    logic              loopSel;
  } coreCfg_t;

  // strobes from bus control to register datapath
  typedef struct packed {
    logic wrEnable;
    logic wrCtrl;
    logic wrPins;
    logic wrBaud;
    logic rdOn;
  } busStrobe_t;
endpackage

// File: rtl/uart_cfg_ctrl.sv
module uart_cfg_ctrl
  import uart_cfg_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              modEnable,
  output busStrobe_t        strobe
);
  logic wrAny;
  logic wrOpen;

  always_comb begin
    wrAny  = busSel & busWr;
    wrOpen = wrAny & modEnable;
    strobe.wrEnable = wrAny  && (busAddr == ADDR_ENABLE);
    strobe.wrCtrl   = wrOpen && (busAddr == ADDR_CTRL);
    strobe.wrPins   = wrOpen && (busAddr == ADDR_PINS);
    strobe.wrBaud   = wrOpen && (busAddr == ADDR_BAUD);
    strobe.rdOn     = busSel & ~busWr;
  end
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              coreTx,
  input  logic              rxPin,
  output logic              modEnable,
  output logic              coreInReset,
  output logic              txRun,
  output logic              rxRun,
  output coreCfg_t          coreCfg,
  output logic              pinSerial,
  output logic              txPin,
  output logic              coreRx
);
  logic              enableQ;
  ctrlReg_t          ctrlQ;
  logic [PINS_W-1:0] pinsQ;
  logic [BAUD_W-1:0] baudQ;
  coreCfg_t          appliedQ;
  coreCfg_t          liveCfg;
  logic              enableNext;
  logic              running;

  always_comb begin
    enableNext = strobe.wrEnable ? busWdata[0] : enableQ;
    running    = enableQ & ctrlQ.softRstN;
    liveCfg.baud         = baudQ;
    liveCfg.twoStop      = ctrlQ.twoStop;
    liveCfg.parityEn     = ctrlQ.parityEn;
    liveCfg.finishOnHalt = ctrlQ.finishOnHalt;
    liveCfg.intClk       = ctrlQ.intClk;
    liveCfg.loopSel      = ctrlQ.loopSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      ctrlQ    <= '0;
      pinsQ    <= '0;
      baudQ    <= '0;
      appliedQ <= '0;
    end else begin
      enableQ <= enableNext;
      if (!enableNext) begin
        ctrlQ <= '0;
        pinsQ <= '0;
        baudQ <= '0;
      end else begin
        if (strobe.wrCtrl) ctrlQ <= ctrlReg_t'(busWdata[CTRL_W-1:0]);
        if (strobe.wrPins) pinsQ <= busWdata[PINS_W-1:0];
        if (strobe.wrBaud) baudQ <= busWdata[BAUD_W-1:0];
      end
      if (running) appliedQ <= liveCfg;
    end
  end

  always_comb begin
    modEnable   = enableQ;
    coreInReset = ~running;
    txRun       = running & ctrlQ.txEn;
    rxRun       = running & ctrlQ.rxEn;
    coreCfg     = running ? liveCfg : appliedQ;
    if (coreCfg.baud == '0) coreCfg.baud = BAUD_W'(1);
    pinSerial   = &pinsQ;
    if (coreCfg.loopSel) begin
      txPin  = 1'b1;
      coreRx = coreTx;
    end else if (pinSerial) begin
      txPin  = coreTx;
      coreRx = rxPin;
    end else begin
      txPin  = 1'b1;
      coreRx = 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobe.rdOn) begin
      unique case (busAddr)
        ADDR_ENABLE: busRdata[0]          = enableQ;
        ADDR_CTRL:   busRdata[CTRL_W-1:0] = ctrlQ;
        ADDR_PINS:   busRdata[PINS_W-1:0] = pinsQ;
        default:     busRdata[BAUD_W-1:0] = baudQ;
      endcase
    end
  end
endmodule

// File: rtl/uart_cfg_gate.sv
module uart_cfg_gate
  import uart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              coreTx,
  input  logic              rxPin,
  output logic              coreInReset,
  output logic              txRun,
  output logic              rxRun,
  output logic              loopOn,
  output logic              clkIntSel,
  output logic              finishOnHalt,
  output logic              parityEn,
  output logic              twoStop,
  output logic [BAUD_W-1:0] baudDiv,
  output logic              pinSerial,
  output logic              txPin,
  output logic              coreRx
);
  busStrobe_t strobe;
  coreCfg_t   coreCfg;
  logic       modEnable;

  uart_cfg_ctrl u_ctrl (
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .modEnable (modEnable),
    .strobe    (strobe)
  );

  uart_cfg_regs u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .coreTx      (coreTx),
    .rxPin       (rxPin),
    .modEnable   (modEnable),
    .coreInReset (coreInReset),
    .txRun       (txRun),
    .rxRun       (rxRun),
    .coreCfg     (coreCfg),
    .pinSerial   (pinSerial),
    .txPin       (txPin),
    .coreRx      (coreRx)
  );

  assign loopOn       = coreCfg.loopSel;
  assign clkIntSel    = coreCfg.intClk;
  assign finishOnHalt = coreCfg.finishOnHalt;
  assign parityEn     = coreCfg.parityEn;
  assign twoStop      = coreCfg.twoStop;
  assign baudDiv      = coreCfg.baud;
endmodule

// File: rtl/uart_cfg_gate_chk.sv
module uart_cfg_gate_chk
  import uart_cfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              modEnable,
  input logic              coreInReset,
  input logic              txRun,
  input logic              rxRun,
  input logic              loopOn,
  input logic [BAUD_W-1:0] baudDiv,
  input logic              pinSerial,
  input logic              coreTx,
  input logic              rxPin,
  input logic              txPin,
  input logic              coreRx
);
  // R2: a write while locked leaves the core settings and the reset state alone
  p_locked_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!modEnable && busSel && busWr && busAddr != ADDR_ENABLE)
      |=> ($stable(baudDiv) && coreInReset));

  // R3: clearing the module enable locks and resets the core next cycle
  p_disable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_ENABLE && !busWdata[0])
      |=> (!modEnable && coreInReset && !txRun && !rxRun));

  // R5: core settings frozen while the core stays in reset
  p_hold_cfg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (coreInReset && $past(coreInReset)) |-> ($stable(baudDiv) && $stable(loopOn)));

  // R6: no transfer permitted while the core is in reset
  p_run_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    coreInReset |-> (!txRun && !rxRun));

  // R7: loopback routes transmit to receive and idles the pin
  p_loopback_r7: assert property (@(posedge clk) disable iff (!rstN)
    loopOn |-> (txPin && coreRx == coreTx));

  // R8: pins idle high when not in serial function and not looped back
  p_pins_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pinSerial && !loopOn) |-> (txPin && coreRx));

  // R9: divisor presented to the core is never zero
  p_baud_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
    baudDiv != '0);
endmodule

bind uart_cfg_gate uart_cfg_gate_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .modEnable   (modEnable),
  .coreInReset (coreInReset),
  .txRun       (txRun),
  .rxRun       (rxRun),
  .loopOn      (loopOn),
  .baudDiv     (baudDiv),
  .pinSerial   (pinSerial),
  .coreTx      (coreTx),
  .rxPin       (rxPin),
  .txPin       (txPin),
  .coreRx      (coreRx)
);

// File: tb/test_uart_cfg_gate.sv
module test_uart_cfg_gate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        coreTx = 1'b1;
  logic        rxPin = 1'b1;
  logic        coreInReset, txRun, rxRun, loopOn, clkIntSel, finishOnHalt;
  logic        parityEn, twoStop, pinSerial, txPin, coreRx;
  logic [23:0] baudDiv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_cfg_gate i_uart_cfg_gate (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .coreTx(coreTx), .rxPin(rxPin),
    .coreInReset(coreInReset), .txRun(txRun), .rxRun(rxRun), .loopOn(loopOn),
    .clkIntSel(clkIntSel), .finishOnHalt(finishOnHalt), .parityEn(parityEn),
    .twoStop(twoStop), .baudDiv(baudDiv), .pinSerial(pinSerial), .txPin(txPin),
    .coreRx(coreRx)
  );

  typedef struct packed {
    logic [1:0]  addr;
    logic [31:0] data;
    logic        expRst;
    logic        expTx;
    logic        expRx;
    logic [23:0] expBaud;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 32'h0000_0007, 1'b1, 1'b0, 1'b0, 24'd1},   // locked ctrl write
    '{2'd3, 32'h0000_0064, 1'b1, 1'b0, 1'b0, 24'd1},   // locked baud write
    '{2'd0, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 24'd1},   // enable module
    '{2'd3, 32'h0000_0064, 1'b1, 1'b0, 1'b0, 24'd1},   // baud while core in reset
    '{2'd1, 32'h0000_0006, 1'b1, 1'b0, 1'b0, 24'd1},   // enables, soft reset still 0
    '{2'd1, 32'h0000_0007, 1'b0, 1'b1, 1'b1, 24'd100}, // release core
    '{2'd1, 32'h0000_0003, 1'b0, 1'b1, 1'b0, 24'd100}, // receiver off
    '{2'd3, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 24'd1},   // zero divisor
    '{2'd3, 32'hFF00_0005, 1'b0, 1'b1, 1'b0, 24'd5},   // upper bits dropped
    '{2'd1, 32'h0000_0002, 1'b1, 1'b0, 1'b0, 24'd5},   // soft reset again
    '{2'd3, 32'h0000_0009, 1'b1, 1'b0, 1'b0, 24'd5},   // held value
    '{2'd1, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 24'd9},   // release, no enables
    '{2'd0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 24'd9},   // disable module
    '{2'd0, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 24'd9}    // re-enable, ctrl cleared
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset defaults
    check("R1 coreInReset", 32'(coreInReset), 32'd1);
    check("R1 txRun", 32'(txRun), 32'd0);
    check("R1 rxRun", 32'(rxRun), 32'd0);
    check("R1 loopOn", 32'(loopOn), 32'd0);
    check("R1 baudDiv", 32'(baudDiv), 32'd1);
    check("R1 txPin", 32'(txPin), 32'd1);
    check("R1 coreRx", 32'(coreRx), 32'd1);
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a), rd);
      check("R1 read", rd, 32'd0);
    end

    // vector table: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VECS[i].addr, VECS[i].data);
      check("R4 coreInReset", 32'(coreInReset), 32'(VECS[i].expRst));
      check("R6 txRun", 32'(txRun), 32'(VECS[i].expTx));
      check("R6 rxRun", 32'(rxRun), 32'(VECS[i].expRx));
      check("R5 R9 baudDiv", 32'(baudDiv), 32'(VECS[i].expBaud));
    end
    busRead(2'd1, rd);
    check("R3 ctrl cleared", rd, 32'd0);

    // R2 locked writes read back reset value
    busWrite(2'd0, 32'd0);
    busWrite(2'd2, 32'd3);
    busRead(2'd2, rd);
    check("R2 locked pins read", rd, 32'd0);
    check("R2 pinSerial", 32'(pinSerial), 32'd0);

    // R3 enable, program, then disable clears
    busWrite(2'd0, 32'd1);
    busWrite(2'd2, 32'd3);
    busRead(2'd2, rd);
    check("R3 pins written", rd, 32'd3);
    busRead(2'd0, rd);
    check("R3 enable read", rd, 32'd1);
    busWrite(2'd0, 32'd0);
    busRead(2'd2, rd);
    check("R3 pins cleared", rd, 32'd0);
    busRead(2'd0, rd);
    check("R3 enable cleared", rd, 32'd0);

    // R5 other settings held until release
    busWrite(2'd0, 32'd1);
    busWrite(2'd1, 32'h0000_00F0);
    check("R5 clkIntSel held", 32'(clkIntSel), 32'd0);
    check("R5 twoStop held", 32'(twoStop), 32'd0);
    busWrite(2'd1, 32'h0000_00F1);
    check("R5 clkIntSel applied", 32'(clkIntSel), 32'd1);
    check("R5 finishOnHalt applied", 32'(finishOnHalt), 32'd1);
    check("R5 parityEn applied", 32'(parityEn), 32'd1);
    check("R5 twoStop applied", 32'(twoStop), 32'd1);

    // R6 clearing soft reset keeps register contents
    busWrite(2'd1, 32'h0000_0007);
    busWrite(2'd1, 32'h0000_0006);
    check("R6 txRun dropped", 32'(txRun), 32'd0);
    busRead(2'd1, rd);
    check("R6 ctrl kept", rd, 32'h0000_0006);

    // R8 pin function
    busWrite(2'd1, 32'h0000_0001);
    busWrite(2'd2, 32'd1);
    coreTx = 1'b0; rxPin = 1'b0; #1;
    check("R8 pinSerial one bit", 32'(pinSerial), 32'd0);
    check("R8 txPin idle", 32'(txPin), 32'd1);
    check("R8 coreRx idle", 32'(coreRx), 32'd1);
    busWrite(2'd2, 32'd3);
    check("R8 pinSerial both", 32'(pinSerial), 32'd1);
    check("R8 txPin follows", 32'(txPin), 32'd0);
    check("R8 coreRx follows", 32'(coreRx), 32'd0);
    rxPin = 1'b1; #1;
    check("R8 coreRx high", 32'(coreRx), 32'd1);

    // R7 loopback
    busWrite(2'd1, 32'h0000_0009);
    coreTx = 1'b0; rxPin = 1'b1; #1;
    check("R7 loopOn", 32'(loopOn), 32'd1);
    check("R7 coreRx looped", 32'(coreRx), 32'd0);
    check("R7 txPin idle", 32'(txPin), 32'd1);
    coreTx = 1'b1; rxPin = 1'b0; #1;
    check("R7 rxPin ignored", 32'(coreRx), 32'd1);

    // R10 read timing and deselect
    busWrite(2'd3, 32'h0012_3456);
    busRead(2'd3, rd);
    check("R10 same-cycle read", rd, 32'h0012_3456);
    busAddr = 2'd3; busSel = 1'b0; #1;
    check("R10 deselected read", busRdata, 32'd0);

    @(negedge clk);
    finishRun();
  end
endmodule